// File: doc/BRIEF.md
# Addressed Serial Control Register File

This block is the control port of a camera analog front-end. A host sends it short words over a three-wire serial link: a serial clock, a serial data line and an active-low enable. Each word names one of five control registers and carries a value for it. The registers drive the gain setting, the white-clip knee, an auxiliary analog level, the converter clamp level, and a set of per-section power-down flags.

All three serial lines are brought into the system clock domain through synchronisers. Serial clock edges and enable edges are then detected there. A word is committed only when the enable returns high, and only if exactly the right number of bits arrived while it was low. A word of any other length is discarded.

The block also gates the converter's sample code on its way to the pads. A global standby input forces the code to zero. An output-enable input withdraws the pad drive enable.

Top module: `ctl_serial_regs`

## Requirements
- R1: A word is 13 bits, sent most significant bit first: a 3-bit register select (bit 12 down to bit 10), then a 10-bit payload P9..P0 (bit 9 down to bit 0). A bit is taken on each rising serial clock edge while the enable input is low. Serial clock edges while the enable is high are not taken.
- R2: Select 0 loads `aux_level` from P7..P0.
- R3: Select 1 loads `clip_level` from P3..P0.
- R4: Select 2 loads `agc_gain` from P8..P0.
- R5: Select 3 loads `pdn_flags` from P3..P0. The flags power down these sections: bit 0 the sampling, gain and clipper path; bit 1 the black clamp and blanking path; bit 2 the auxiliary level converter; bit 3 the fixed-gain analog output.
- R6: Select 4 loads `clamp_ref` from P9..P0.
- R7: A register is written only when the enable rises after exactly 13 bits were taken in that low window. Shorter and longer words change no register.
- R8: Selects 5, 6 and 7 change no register.
- R9: After reset every control register reads zero and `sample_out` reads zero.
- R10: `sample_out` follows `adc_code` one clock later. When `stdby` was high at that clock edge, `sample_out` is zero instead.
- R11: `sample_oe` is high when `oe_n` is low, and low when `oe_n` is high.
- R12: A write to one register leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data |
| sen_n | input | 1 | Serial enable, active low |
| stdby | input | 1 | Global standby; forces the sample code to zero |
| oe_n | input | 1 | Output enable for the sample pads, active low |
| adc_code | input | SAMPLE_W (10) | Converter sample code |
| aux_level | output | 8 | Auxiliary level setting |
| clip_level | output | 4 | Soft-clip knee setting |
| agc_gain | output | 9 | Gain setting |
| pdn_flags | output | 4 | Per-section power-down flags |
| clamp_ref | output | 10 | Clamp reference level |
| sample_out | output | SAMPLE_W (10) | Gated, registered sample code |
| sample_oe | output | 1 | Pad drive enable for sample_out |

## Verification
The bit counter or the shift register could fall out of step with the serial clock. That fault shows as a wrong value in a register, or as a missing or extra register change. It appears a few system clocks after the enable rises, so every word is followed by a comparison of all five registers against a shadow model. Length faults and select-decode faults show only as a change that should not happen. Words of 12 and 14 bits, and writes to selects 5 to 7, are each followed by a full compare that expects nothing to have moved.

// File: rtl/scrf_pkg.sv
package scrf_pkg;
   localparam int ADDR_W    = 3;
   localparam int PAYLOAD_W = 10;
   localparam int FRAME_W   = ADDR_W + PAYLOAD_W;
   localparam int AUX_W     = 8;
   localparam int CLIP_W    = 4;
   localparam int GAIN_W    = 9;
   localparam int PDN_W     = 4;
   localparam int CLAMP_W   = 10;

   typedef enum logic [ADDR_W-1:0] {
      SEL_AUX   = 3'd0,
      SEL_CLIP  = 3'd1,
      SEL_GAIN  = 3'd2,
      SEL_PDN   = 3'd3,
      SEL_CLAMP = 3'd4
   } sel_e;
endpackage

// File: rtl/scrf_sync.sv
module scrf_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scrf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else if (s == 0) stg[s] <= d;
            else stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/scrf_shift.sv
module scrf_shift
   import scrf_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               sdata_s,
   input  logic               sen_s,
   output logic               frame_vld,
   output logic [FRAME_W-1:0] frame_q
);
   localparam int CNT_MAX = FRAME_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic               sclk_q, sen_q;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] shreg;
   logic               sclk_rise, sen_fall, sen_rise, take, full;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign sen_fall  = ~sen_s & sen_q;
   assign sen_rise  = sen_s & ~sen_q;
   assign take      = ~sen_s & sclk_rise;
   assign full      = (cnt == CNT_W'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         sen_q     <= 1'b1;
         cnt       <= '0;
         shreg     <= '0;
         frame_vld <= 1'b0;
         frame_q   <= '0;
      end else begin
         sclk_q    <= sclk_s;
         sen_q     <= sen_s;
         frame_vld <= sen_rise & full;
         if (sen_rise && full) frame_q <= shreg;
         if (take) begin
            shreg <= {shreg[FRAME_W-2:0], sdata_s};
            if (sen_fall) cnt <= CNT_W'(1);
            else if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
         end else if (sen_fall) begin
            cnt <= '0;
         end
      end
   end

   AST_VLD_ENABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |-> sen_s);                                   // R7
   AST_VLD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |=> !frame_vld);                              // R7
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CNT_MAX));                                // R1
endmodule

// File: rtl/scrf_regs.sv
module scrf_regs
   import scrf_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_vld,
   input  logic [FRAME_W-1:0] frame_q,
   output logic [AUX_W-1:0]   aux_level,
   output logic [CLIP_W-1:0]  clip_level,
   output logic [GAIN_W-1:0]  agc_gain,
   output logic [PDN_W-1:0]   pdn_flags,
   output logic [CLAMP_W-1:0] clamp_ref
);
   logic [ADDR_W-1:0]    sel;
   logic [PAYLOAD_W-1:0] pay;

   assign sel = frame_q[FRAME_W-1 -: ADDR_W];
   assign pay = frame_q[PAYLOAD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_level  <= '0;
         clip_level <= '0;
         agc_gain   <= '0;
         pdn_flags  <= '0;
         clamp_ref  <= '0;
      end else if (frame_vld) begin
         case (sel)
            SEL_AUX:   aux_level  <= pay[AUX_W-1:0];
            SEL_CLIP:  clip_level <= pay[CLIP_W-1:0];
            SEL_GAIN:  agc_gain   <= pay[GAIN_W-1:0];
            SEL_PDN:   pdn_flags  <= pay[PDN_W-1:0];
            SEL_CLAMP: clamp_ref  <= pay[CLAMP_W-1:0];
            default:   ;
         endcase
      end
   end

   AST_NO_WRITE_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_vld) |-> $stable({aux_level, clip_level, agc_gain, pdn_flags, clamp_ref})); // R7
   AST_HIGH_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(frame_vld) && $past(sel) > 3'd4)
         |-> $stable({aux_level, clip_level, agc_gain, pdn_flags, clamp_ref}));                // R8
   AST_GAIN_ONLY_BY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(frame_vld) && $past(sel) != 3'd2) |-> $stable(agc_gain));                        // R12
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
   import scrf_pkg::*;
#(
   parameter int SAMPLE_W    = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk,
   input  logic                sdata,
   input  logic                sen_n,
   input  logic                stdby,
   input  logic                oe_n,
   input  logic [SAMPLE_W-1:0] adc_code,
   output logic [7:0]          aux_level,
   output logic [3:0]          clip_level,
   output logic [8:0]          agc_gain,
   output logic [3:0]          pdn_flags,
   output logic [9:0]          clamp_ref,
   output logic [SAMPLE_W-1:0] sample_out,
   output logic                sample_oe
);
   generate
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("ctl_serial_regs: SAMPLE_W must be positive");
      end
   endgenerate

   logic [2:0]         ser_s;
   logic               frame_vld;
   logic [FRAME_W-1:0] frame_q;

   scrf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sen_n, sclk, sdata}),
      .q    (ser_s)
   );

   scrf_shift u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (ser_s[1]),
      .sdata_s  (ser_s[0]),
      .sen_s    (ser_s[2]),
      .frame_vld(frame_vld),
      .frame_q  (frame_q)
   );

   scrf_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_vld (frame_vld),
      .frame_q   (frame_q),
      .aux_level (aux_level),
      .clip_level(clip_level),
      .agc_gain  (agc_gain),
      .pdn_flags (pdn_flags),
      .clamp_ref (clamp_ref)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample_out <= '0;
      else        sample_out <= stdby ? '0 : adc_code;
   end

   assign sample_oe = ~oe_n;

   AST_STANDBY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stdby) |-> (sample_out == '0));                   // R10
   AST_SAMPLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stdby) |-> (sample_out == $past(adc_code)));     // R10
endmodule

// File: tb/ctl_serial_regs_bench.sv
module ctl_serial_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, sdata = 1'b0, sen_n = 1'b1;
   logic       stdby = 1'b0, oe_n = 1'b0;
   logic [9:0] adc_code = '0;
   logic [7:0] aux_level;
   logic [3:0] clip_level;
   logic [8:0] agc_gain;
   logic [3:0] pdn_flags;
   logic [9:0] clamp_ref;
   logic [9:0] sample_out;
   logic       sample_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [34:0] exp_q[$];
   string       tag_q[$];
   event        item_ev;
   logic [7:0]  m_aux = '0;
   logic [3:0]  m_clip = '0;
   logic [8:0]  m_gain = '0;
   logic [3:0]  m_pdn = '0;
   logic [9:0]  m_clamp = '0;

   always #5 clk = ~clk;

   ctl_serial_regs u_ctl_serial_regs (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sen_n(sen_n),
      .stdby(stdby), .oe_n(oe_n), .adc_code(adc_code),
      .aux_level(aux_level), .clip_level(clip_level), .agc_gain(agc_gain),
      .pdn_flags(pdn_flags), .clamp_ref(clamp_ref),
      .sample_out(sample_out), .sample_oe(sample_oe)
   );

   task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic send_bits(input int n, input logic [15:0] v);
      @(negedge clk) sen_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         sdata = v[i];
         repeat (4) @(negedge clk);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      sen_n = 1'b1;
   endtask

   // driver: sends a word, updates the shadow model, pushes the expected item
   task automatic write_word(input string tag, input int n, input logic [15:0] v);
      logic [2:0] a;
      logic [9:0] p;
      send_bits(n, v);
      a = v[12:10];
      p = v[9:0];
      if (n == 13) begin
         case (a)
            3'd0: m_aux   = p[7:0];
            3'd1: m_clip  = p[3:0];
            3'd2: m_gain  = p[8:0];
            3'd3: m_pdn   = p[3:0];
            3'd4: m_clamp = p;
            default: ;
         endcase
      end
      exp_q.push_back({m_aux, m_clip, m_gain, m_pdn, m_clamp});
      tag_q.push_back(tag);
      -> item_ev;
      repeat (14) @(negedge clk);
   endtask

   // monitor: compares the full register set a fixed time after each word
   initial begin
      forever begin
         @(item_ev);
         repeat (8) @(negedge clk);
         check(tag_q.pop_front(),
               {aux_level, clip_level, agc_gain, pdn_flags, clamp_ref},
               exp_q.pop_front());
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 reset registers", {aux_level, clip_level, agc_gain, pdn_flags, clamp_ref}, '0);
      check("R9 reset sample", 35'(sample_out), '0);

      write_word("R2 aux from P7..P0",      13, {3'd0, 10'h3FF});
      write_word("R3 clip from P3..P0",     13, {3'd1, 10'h2A5});
      write_word("R4 gain full",            13, {3'd2, 10'h1FF});
      write_word("R4 gain drops P9",        13, {3'd2, 10'h30A});
      write_word("R5 all pdn flags",        13, {3'd3, 10'h00F});
      write_word("R5 pdn path and aux dac", 13, {3'd3, 10'h3F5});
      write_word("R6 clamp ref",            13, {3'd4, 10'h2C3});
      write_word("R12 aux rewrite",         13, {3'd0, 10'h05A});
      write_word("R7 short word",           12, 16'h0FFF);
      write_word("R7 long word",            14, {1'b0, 3'd4, 10'h111});
      write_word("R8 select 5",             13, {3'd5, 10'h3FF});
      write_word("R8 select 7",             13, {3'd7, 10'h155});

      // R1: serial clock pulses with enable high must not be taken
      sdata = 1'b1;
      for (int k = 0; k < 3; k++) begin
         repeat (4) @(negedge clk) sclk = 1'b1;
         repeat (4) @(negedge clk) sclk = 1'b0;
      end
      write_word("R1 order after idle clocks", 13, {3'd1, 10'h009});
      write_word("R1 clamp bit order",         13, {3'd4, 10'h201});

      // R10 / R11 sample gating
      @(negedge clk) adc_code = 10'h155;
      @(negedge clk);
      check("R10 sample follows", 35'(sample_out), 35'h155);
      stdby = 1'b1;
      @(negedge clk);
      check("R10 standby zero", 35'(sample_out), 35'h0);
      stdby = 1'b0; adc_code = 10'h2AA;
      @(negedge clk);
      check("R10 sample after standby", 35'(sample_out), 35'h2AA);
      check("R11 oe active", 35'(sample_oe), 35'h1);
      oe_n = 1'b1;
      #1;
      check("R11 oe withdrawn", 35'(sample_oe), 35'h0);

      repeat (20) @(negedge clk);
      finish_run();
   end
endmodule